// File: doc/BRIEF.md
# Triggered Pulse Burst Sequencer

A synchronous Moore controller whose single-bit output stays low while idle. A trigger sampled high at a rising clock edge starts a fixed burst of four output cycles with the values 1, 1, 0, 1. After the burst the controller goes back to idle. Once a burst has started it runs to the end without looking at the trigger. The trigger is not stored, so a request that arrives while a burst is playing is lost. A trigger that is high during the last burst cycle is also ignored, because that cycle belongs to the burst and not to idle. A trigger that is high during the first idle cycle after the burst starts a new burst at the next edge.

There are five named states. `ST_IDLE` drives 0. `ST_P0` drives 1, `ST_P1` drives 1, `ST_P2` drives 0 and `ST_P3` drives 1. The transitions are:
- `arm`: `ST_IDLE` to `ST_P0` when the trigger is 1.
- `hold`: `ST_IDLE` to `ST_IDLE` when the trigger is 0.
- `step`: `ST_P0` to `ST_P1`, `ST_P1` to `ST_P2` and `ST_P2` to `ST_P3`, each taken unconditionally.
- `done`: `ST_P3` to `ST_IDLE`, taken unconditionally.

Any unused encoding goes to `ST_IDLE`.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `ST_IDLE`, so `pulse_o` is 0 in the cycle after the edge.
- R2: In `ST_IDLE`, `pulse_o` is 0. If `trig_i` is 0 at an edge, the controller stays idle.
- R3: If `trig_i` is 1 at an edge while the controller is idle, `pulse_o` reads 1, 1, 0, 1 over the next four cycles, one value per cycle.
- R4: Changes of `trig_i` during those four cycles have no effect on `pulse_o`.
- R5: After the fourth burst cycle, `pulse_o` is 0 for at least one cycle. If `trig_i` is high during that idle cycle, the next burst begins at the following edge.
- R6: `pulse_o` depends only on the registered state. It changes only after rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Burst request, sampled at rising edges while idle |
| pulse_o | output | 1 | Burst output |

## Verification
A wrong internal state shows at `pulse_o` within at most five cycles. A state that was skipped or repeated shifts the 1,1,0,1 pattern or changes its length, and a per-cycle comparison catches that in the first cycle that differs. A controller that does not return to idle, or that accepts a trigger in the middle of a burst, shows up as an extra 1 or a missing idle cycle right after the burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_P0   = 3'd1,
        ST_P1   = 3'd2,
        ST_P2   = 3'd3,
        ST_P3   = 3'd4
    } burst_state_t;

    localparam int unsigned BURST_LEN = 4;
    localparam logic [BURST_LEN-1:0] BURST_BITS = 4'b1011; // bit0 is played first
endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);
    burst_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = trig_i ? ST_P0 : ST_IDLE;
            ST_P0:   state_d = ST_P1;
            ST_P1:   state_d = ST_P2;
            ST_P2:   state_d = ST_P3;
            ST_P3:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            ST_IDLE: pulse_o = 1'b0;
            ST_P0:   pulse_o = BURST_BITS[0];
            ST_P1:   pulse_o = BURST_BITS[1];
            ST_P2:   pulse_o = BURST_BITS[2];
            ST_P3:   pulse_o = BURST_BITS[3];
            default: pulse_o = 1'b0;
        endcase
    end

    // R1: reset lands in idle with output low
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !pulse_o));

    // R2: idle without trigger stays idle
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !trig_i) |=> (state_q == ST_IDLE));

    // R3: trigger while idle starts the burst with a high output
    a_r3_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && trig_i) |=> (state_q == ST_P0 && pulse_o));

    // R4: third burst cycle is low regardless of trigger
    a_r4_mid_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_P1) |=> !pulse_o);

    // R5: burst end always returns to idle
    a_r5_return: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_P3) |=> (state_q == ST_IDLE && !pulse_o));

    // R6: state is always one of the defined encodings after reset
    a_r6_legal: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {ST_IDLE, ST_P0, ST_P1, ST_P2, ST_P3}));
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_i = 1'b0;
    logic pulse_o;

    int checks = 0;
    int fails  = 0;
    int remain = 0;
    int pos    = 0;
    bit exp_out = 1'b0;
    int cyc = 0;
    bit done = 1'b0;

    burst_seq u_burst_seq (.clk(clk), .rst(rst), .trig_i(trig_i), .pulse_o(pulse_o));

    always #5 clk = ~clk;

    function automatic bit pat(input int p);
        case (p)
            0: return 1'b1;
            1: return 1'b1;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Behavioural model: a countdown of remaining burst cycles, updated at each edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            remain <= 0;
        end else if (remain == 0) begin
            if (trig_i) begin
                remain <= 4;
                pos <= 0;
            end
        end else begin
            remain <= remain - 1;
            pos <= pos + 1;
        end
    end

    always_comb exp_out = (remain == 0) ? 1'b0 : pat(pos);

    // Compare on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            checks++;
            if (pulse_o !== exp_out) begin
                fails++;
                $display("FAIL %s cycle %0d: pulse_o=%b expected %b",
                         (remain == 0) ? "R2/R5" : "R3/R4", cyc, pulse_o, exp_out);
            end
        end
    end

    task automatic tick(input bit t);
        trig_i = t;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (pulse_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: pulse_o=%b expected 0", pulse_o);
        end
        rst = 1'b0;
        // R2: idle hold
        for (int i = 0; i < 3; i++) tick(1'b0);
        // R3: single burst
        tick(1'b1);
        for (int i = 0; i < 6; i++) tick(1'b0);
        // R4: trigger held high throughout; R5 back-to-back after one idle
        for (int i = 0; i < 12; i++) tick(1'b1);
        // R4: trigger toggling
        tick(1'b1);
        for (int i = 0; i < 8; i++) tick(i[0]);
        for (int i = 0; i < 4; i++) tick(1'b0);
        // R1: reset in mid-burst
        tick(1'b1);
        tick(1'b0);
        rst = 1'b1;
        tick(1'b0);
        rst = 1'b0;
        // R6: pattern after reset is intact
        tick(1'b1);
        for (int i = 0; i < 6; i++) tick(1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: hung run, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule